// File: doc/BRIEF.md
# Descriptor Ring Position Counter

This block keeps track of where one direction of a network controller (receive or transmit) currently stands in its circular ring of buffer descriptors. It holds two small registers. One is the ring length register, which stores the negated descriptor count. The other is the position counter, which climbs by one toward zero. A counter value of zero marks the last descriptor in the ring. The next advance from zero reloads the counter, so the ring starts again at the first descriptor.

The initialization sequence loads the ring through a dedicated port that carries the plain descriptor count; the block negates it itself. Software may then overwrite either register through a small host port, but only while the controller is held stopped. The block also presents a zero-based descriptor index for address generation and a flag for the last descriptor.

The counter value for the first descriptor is one above the length register contents. With that choice a ring of N descriptors occupies exactly the N counter values -(N-1) through 0. A ring of one descriptor therefore sits permanently at zero.

Top module: `ring_pos_counter`

## Requirements
- R1: After reset the length register and the position counter are both zero.
- R2: A pulse on initLoad with initCount = N stores (2^W - N) mod 2^W in the length register and sets the counter to that value plus one. This is the first descriptor, index 0.
- R3: An advance while the counter is nonzero adds one to the counter.
- R4: An advance while the counter is zero (the last descriptor) loads the counter with the length register plus one. atLast is high exactly when the counter is zero.
- R5: descIdx always equals (counter - length - 1) mod 2^W.
- R6: With a length register of all ones (a ring of one descriptor), the counter stays at zero on every advance.
- R7: A host write with hostAddr = 0 loads the counter and a write with hostAddr = 1 loads the length register. Both take the low W bits of hostWrData. A write is ignored while stopHeld is low.
- R8: While stopHeld is high, hostRdData returns the counter (hostAddr = 0) or the length register (hostAddr = 1), zero-extended; bits W and above read as zero. While stopHeld is low, hostRdData is zero.
- R9: initLoad takes priority over a host write in the same cycle, and a host write of the counter takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stopHeld | input | 1 | Controller is stopped; enables host access |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 1 | 0 = position counter, 1 = length register |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data |
| initLoad | input | 1 | Load ring from initialization count |
| initCount | input | CNT_W | Number of descriptors for initLoad |
| advance | input | 1 | Step to the next descriptor |
| posCount | output | CNT_W | Position counter value |
| ringLen | output | CNT_W | Length register value |
| descIdx | output | CNT_W | Zero-based descriptor index |
| atLast | output | 1 | Counter is on the last descriptor |

## Verification
The bench builds the block with CNT_W = 4 and DATA_W = 32. This puts every legal ring size from 1 to 15 descriptors within reach of a full walk through two complete wraps. It also allows all 256 combinations of written length and written position to be swept, each followed by an advance. The wide host word still exercises the zero upper bits, and the small counter makes the one-descriptor ring and the wrap from zero frequent events.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef struct packed {
    logic loadInit;
    logic wrPos;
    logic wrLen;
    logic step;
  } ringStrobes_t;
endpackage

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import ring_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              stopHeld,
  input  logic              hostWrEn,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              initLoad,
  input  logic              advance,
  input  logic [CNT_W-1:0]  posVal,
  input  logic [CNT_W-1:0]  lenVal,
  output ringStrobes_t      strobes,
  output logic [CNT_W-1:0]  wrVal,
  output logic [DATA_W-1:0] hostRdData
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic hostWrOk;

  always_comb begin
    hostWrOk         = hostWrEn && stopHeld && !initLoad;
    strobes.loadInit = initLoad;
    strobes.wrPos    = hostWrOk && (hostAddr == 1'b0);
    strobes.wrLen    = hostWrOk && (hostAddr == 1'b1);
    strobes.step     = advance && !initLoad && !strobes.wrPos;
    wrVal            = hostWrData[CNT_W-1:0];
  end

  always_comb begin
    hostRdData = '0;
    if (stopHeld) begin
      if (hostAddr) hostRdData = {{PAD_W{1'b0}}, lenVal};
      else          hostRdData = {{PAD_W{1'b0}}, posVal};
    end
  end

  always_comb begin
    assert (!(strobes.wrPos && strobes.wrLen))
      else $error("p_single_target_r7");
  end
endmodule

// File: rtl/ring_dpath.sv
module ring_dpath
  import ring_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobes_t     strobes,
  input  logic [CNT_W-1:0] wrVal,
  input  logic [CNT_W-1:0] initCount,
  output logic [CNT_W-1:0] posVal,
  output logic [CNT_W-1:0] lenVal,
  output logic [CNT_W-1:0] descIdx,
  output logic             atLast
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] negCount;
  logic [CNT_W-1:0] firstPos;
  logic [CNT_W-1:0] nextPos;
  logic [CNT_W-1:0] nextLen;

  always_comb begin
    negCount = '0 - initCount;
    firstPos = lenVal + ONE;
    atLast   = (posVal == '0);
    descIdx  = posVal - lenVal - ONE;
  end

  always_comb begin
    nextPos = posVal;
    nextLen = lenVal;
    if (strobes.loadInit) begin
      nextLen = negCount;
      nextPos = negCount + ONE;
    end else begin
      if (strobes.wrLen) nextLen = wrVal;
      if (strobes.wrPos)     nextPos = wrVal;
      else if (strobes.step) nextPos = atLast ? firstPos : posVal + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posVal <= '0;
      lenVal <= '0;
    end else begin
      posVal <= nextPos;
      lenVal <= nextLen;
    end
  end

  p_init_len_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadInit |=> (lenVal == '0 - $past(initCount)));

  p_step_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.loadInit && !strobes.wrPos && posVal != '0)
      |=> (posVal == $past(posVal) + ONE));

  p_wrap_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.loadInit && !strobes.wrPos && posVal == '0)
      |=> (posVal == $past(lenVal) + ONE));

  p_single_ring_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.loadInit && !strobes.wrPos && !strobes.wrLen &&
     posVal == '0 && lenVal == '1) |=> (posVal == '0));
endmodule

// File: rtl/ring_pos_counter.sv
module ring_pos_counter
  import ring_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stopHeld,
  input  logic              hostWrEn,
  input  logic              hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              initLoad,
  input  logic [CNT_W-1:0]  initCount,
  input  logic              advance,
  output logic [CNT_W-1:0]  posCount,
  output logic [CNT_W-1:0]  ringLen,
  output logic [CNT_W-1:0]  descIdx,
  output logic              atLast
);
  ringStrobes_t     strobes;
  logic [CNT_W-1:0] wrVal;

  ring_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ctrl (
    .stopHeld  (stopHeld),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .initLoad  (initLoad),
    .advance   (advance),
    .posVal    (posCount),
    .lenVal    (ringLen),
    .strobes   (strobes),
    .wrVal     (wrVal),
    .hostRdData(hostRdData)
  );

  ring_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrVal    (wrVal),
    .initCount(initCount),
    .posVal   (posCount),
    .lenVal   (ringLen),
    .descIdx  (descIdx),
    .atLast   (atLast)
  );

  p_len_held_running_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!stopHeld && !initLoad) |=> (ringLen == $past(ringLen)));

  p_read_zero_running_r8: assert property (@(posedge clk) disable iff (!rstN)
    !stopHeld |-> (hostRdData == '0));

  p_init_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (initLoad && hostWrEn) |=> (ringLen == '0 - $past(initCount)));
endmodule

// File: tb/ring_pos_counter_test.sv
module ring_pos_counter_test;
  localparam int CW = 4;
  localparam int DW = 32;
  localparam int M  = 1 << CW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          stopHeld = 1'b1;
  logic          hostWrEn = 1'b0;
  logic          hostAddr = 1'b0;
  logic [DW-1:0] hostWrData = '0;
  logic [DW-1:0] hostRdData;
  logic          initLoad = 1'b0;
  logic [CW-1:0] initCount = '0;
  logic          advance = 1'b0;
  logic [CW-1:0] posCount, ringLen, descIdx;
  logic          atLast;

  int total = 0;
  int bad = 0;
  int expLen = 0;
  int expPos = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ring_pos_counter #(.CNT_W(CW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .stopHeld(stopHeld), .hostWrEn(hostWrEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .initLoad(initLoad), .initCount(initCount), .advance(advance),
    .posCount(posCount), .ringLen(ringLen), .descIdx(descIdx), .atLast(atLast)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    hostWrEn = 1'b0; initLoad = 1'b0; advance = 1'b0;
  endtask

  task automatic checkState(string req);
    check({req, " pos"}, posCount, expPos);
    check({req, " len"}, ringLen, expLen);
    check({req, " R5 idx"}, descIdx, (expPos - expLen - 1) & (M - 1));
    check({req, " R4 last"}, atLast, expPos == 0);
  endtask

  task automatic modelStep();
    if (expPos == 0) expPos = (expLen + 1) & (M - 1);
    else             expPos = (expPos + 1) & (M - 1);
  endtask

  task automatic hostWrite(bit a, int v);
    hostWrEn = 1'b1; hostAddr = a;
    hostWrData = 32'hABCD_0000 | 32'(v) | 32'h0000_FF00;
    tick();
  endtask

  task automatic readCheck(string req, bit a, int exp);
    hostAddr = a;
    #1;
    check(req, hostRdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 pos", posCount, 0);
    check("R1 len", ringLen, 0);
    rstN = 1'b1;
    @(negedge clk);
    readCheck("R1 read pos", 1'b0, 0);
    readCheck("R1 read len", 1'b1, 0);

    // R2/R3/R4/R6: every ring size, two full wraps
    for (int n = 1; n < M; n++) begin
      initLoad = 1'b1; initCount = CW'(n);
      tick();
      expLen = (M - n) & (M - 1);
      expPos = (expLen + 1) & (M - 1);
      checkState("R2 init");
      check("R2 idx zero", descIdx, 0);
      for (int k = 1; k <= 2 * n + 1; k++) begin
        advance = 1'b1;
        tick();
        modelStep();
        checkState(n == 1 ? "R6 single" : "R3 R4 step");
        check("R5 idx mod", descIdx, k % n);
      end
    end

    // R7/R8: written length and position, then one advance
    for (int l = 0; l < M; l++) begin
      for (int p = 0; p < M; p++) begin
        hostWrite(1'b1, l);
        hostWrite(1'b0, p);
        expLen = l; expPos = p;
        readCheck("R8 read len", 1'b1, l);
        readCheck("R8 read pos", 1'b0, p);
        checkState("R7 write");
        advance = 1'b1;
        tick();
        modelStep();
        checkState("R4 after write");
      end
    end

    // R7/R8: running controller ignores writes, reads zero
    expLen = 5; expPos = 9;
    hostWrite(1'b1, expLen);
    hostWrite(1'b0, expPos);
    stopHeld = 1'b0;
    @(negedge clk);
    readCheck("R8 running read len", 1'b1, 0);
    readCheck("R8 running read pos", 1'b0, 0);
    hostWrite(1'b1, 2);
    hostWrite(1'b0, 3);
    stopHeld = 1'b1;
    #1;
    checkState("R7 ignored running");
    readCheck("R7 ignored len", 1'b1, 5);

    // R9: init beats host write
    initLoad = 1'b1; initCount = CW'(6);
    hostWrEn = 1'b1; hostAddr = 1'b1; hostWrData = 32'd1;
    tick();
    expLen = M - 6; expPos = M - 5;
    checkState("R9 init wins");
    // R9: position write beats advance
    advance = 1'b1; hostWrEn = 1'b1; hostAddr = 1'b0; hostWrData = 32'd7;
    tick();
    expPos = 7;
    checkState("R9 write wins");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule